// File: doc/BRIEF.md
# Up-Down PWM Channel Pair with Action Tables

This block generates two pulse-width-modulated outputs from one time-base counter that climbs from zero to a programmed period and then falls back to zero. A cycle therefore spans twice the period in time-base ticks. Ticks come from an external clock enable, slowed by two cascaded prescale fields. Two compare values select where the edges fall inside the cycle. Each compare can be written directly or through a shadow copy that moves into service only when the counter is at zero, so a new duty value never splits a cycle.

Every output has its own table of six events: zero, period, and compare A and compare B matches, each split by counting direction. For each event the table gives a 2-bit action that sets, clears, toggles or leaves the output alone. One selectable event source drives a sticky interrupt request, which rises only on every Nth occurrence of that source. Software reaches all settings through a write-only port made of an enable, an address and a data word. A phase register and a phase-load bit are present, but loading stays permanently disabled.

Top module: `updown_pwm`

## Requirements
- R1: A synchronous active-high reset clears the counter, both outputs, all period, shadow and active compare registers, all tables and the interrupt flag, and leaves the direction at up.
- R2: While running, the counter steps by one on each tick. Counting up, it reverses at the period value. Counting down, it reverses at zero. One cycle lasts 2*period ticks. When the count is already at or above the period while counting up, the counter turns down. A period of zero holds the count at zero.
- R3: A tick occurs once every (HS+1)*2^CK asserted clock enables, with HS = control bits [3:1] and CK = control bits [6:4]. Control bit 0 is the run bit. With run low, the prescaler resets and the counter holds.
- R4: When the shadow bit of a compare is set (mode register bit 0 for A, bit 1 for B), a write to that compare (address 4 for A, 5 for B) goes to the shadow. The shadow moves into the active compare on a tick in which the count is zero. Until then, matches keep using the old value.
- R5: When the shadow bit is clear, a compare write takes effect on the next clock.
- R6: Action codes are 00 none, 01 clear, 10 set, 11 toggle. Table bits per output (address 7 for A, 8 for B) are [1:0] zero, [3:2] period, [5:4] A-up, [7:6] A-down, [9:8] B-up, [11:10] B-down. Outputs change only on ticks.
- R7: A compare match uses the up entry when the current direction is up and the down entry otherwise. A match at the period value counts as up. A match at zero counts as down, except right after reset or a counter write of zero.
- R8: When several events with non-zero actions occur on one tick, only one action applies. Zero has the highest priority, then period, then A-up, A-down, B-up and B-down.
- R9: Interrupt control (address 9) uses bit 0 as enable, bits [2:1] as source (00 zero, 01 period, 10 zero or period, 11 A-up match) and bits [5:3] as N. The flag sets on every Nth selected event, and the event count then restarts. An N of 0 never sets the flag.
- R10: The flag stays set until a write to address 10 with data bit 0 = 1. A write with bit 0 = 0 has no effect. A set in the same cycle as a clear wins.
- R11: A write to address 1 replaces the count and overrides that tick's step. Writing zero forces the direction to up. Any other value keeps the direction.
- R12: The phase register (address 2) and control bit 7 never load or disturb the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Time-base clock enable fed to the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Register write data |
| cnt_out | output | CNT_W | Current time-base count |
| dir_up | output | 1 | Current counting direction, 1 = up |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| irq | output | 1 | Sticky interrupt request |

## Verification
The hardest situations to reach are ticks on which two events with non-zero actions coincide. One example is a compare of zero that matches together with the zero event. Another is a compare at the period value, where the direction flips right after the match. The bench reaches these by writing compares of 0 and of the period. It chooses table codes so that the outcome differs depending on which event wins. It also sweeps every compare value from 0 to the period for several small periods, comparing every output on every clock against a cycle-level model computed from the requirements.

// File: rtl/updown_pwm_pkg.sv
package updown_pwm_pkg;
  typedef enum logic [1:0] {
    AQ_NONE = 2'b00,
    AQ_CLR  = 2'b01,
    AQ_SET  = 2'b10,
    AQ_TGL  = 2'b11
  } aq_code_t;

  // bit 0 is the highest-priority event
  typedef struct packed {
    logic cb_dn;
    logic cb_up;
    logic ca_dn;
    logic ca_up;
    logic prd;
    logic zero;
  } tb_evt_t;

  localparam int NUM_EVT = 6;
  localparam int TBL_W   = 2 * NUM_EVT;

  localparam int A_PRD    = 0;
  localparam int A_CNT    = 1;
  localparam int A_PHS    = 2;
  localparam int A_CTRL   = 3;
  localparam int A_CMPA   = 4;
  localparam int A_CMPB   = 5;
  localparam int A_CMPCTL = 6;
  localparam int A_AQA    = 7;
  localparam int A_AQB    = 8;
  localparam int A_ETSEL  = 9;
  localparam int A_INTCLR = 10;
endpackage

// File: rtl/updown_pwm_prescale.sv
module updown_pwm_prescale #(
  parameter int HS_W = 3,
  parameter int CK_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            clk_en,
  input  logic [HS_W-1:0] hs,
  input  logic [CK_W-1:0] ck,
  output logic            tick
);
  localparam int DIV_W = HS_W + (1 << CK_W);

  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] pre_cnt;
  logic             at_end;

  always_comb begin
    div    = DIV_W'({1'b0, hs} + 1'b1) << ck;
    at_end = (pre_cnt == div - 1'b1);
    tick   = run && clk_en && at_end;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt <= '0;
    end else if (clk_en) begin
      pre_cnt <= at_end ? '0 : pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/updown_pwm_counter.sv
module updown_pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_up
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (load) begin
      cnt <= load_val;
      if (load_val == '0) dir_up <= 1'b1;
    end else if (tick) begin
      if (dir_up) begin
        if (cnt >= period) begin
          if (cnt != '0) begin
            dir_up <= 1'b0;
            cnt    <= cnt - 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cnt == '0) begin
          dir_up <= 1'b1;
          if (period != '0) cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/updown_pwm_aq.sv
module updown_pwm_aq
  import updown_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  tb_evt_t          evt,
  input  logic [TBL_W-1:0] tbl,
  output logic             q
);
  logic [NUM_EVT-1:0] ev_vec;
  aq_code_t           code;

  always_comb begin
    ev_vec = evt;
    code   = AQ_NONE;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (ev_vec[i] && tbl[2*i +: 2] != 2'b00) code = aq_code_t'(tbl[2*i +: 2]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (tick) begin
      case (code)
        AQ_CLR:  q <= 1'b0;
        AQ_SET:  q <= 1'b1;
        AQ_TGL:  q <= ~q;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/updown_pwm_evtrig.sv
module updown_pwm_evtrig
  import updown_pwm_pkg::*;
#(
  parameter int EVN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  tb_evt_t          evt,
  input  logic             en,
  input  logic [1:0]       src_sel,
  input  logic [EVN_W-1:0] n_evt,
  input  logic             clr,
  output logic             flag
);
  logic [EVN_W-1:0] ecnt;
  logic [EVN_W-1:0] ecnt_nxt;
  logic             src;
  logic             hit;
  logic             fire;

  always_comb begin
    case (src_sel)
      2'b00:   src = evt.zero;
      2'b01:   src = evt.prd;
      2'b10:   src = evt.zero | evt.prd;
      default: src = evt.ca_up;
    endcase
    hit      = tick && en && (n_evt != '0) && src;
    ecnt_nxt = ecnt + 1'b1;
    fire     = hit && (ecnt_nxt == n_evt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ecnt <= '0;
      flag <= 1'b0;
    end else begin
      if (hit) ecnt <= fire ? '0 : ecnt_nxt;
      if (fire)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/updown_pwm.sv
module updown_pwm
  import updown_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int HS_W   = 3,
  parameter int CK_W   = 3,
  parameter int EVN_W  = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  cnt_out,
  output logic              dir_up,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic              irq
);
  localparam int HS_LO = 1;
  localparam int CK_LO = HS_LO + HS_W;
  localparam int N_LO  = 3;
  localparam logic PHASE_LOAD_EN = 1'b0;

  logic [CNT_W-1:0] prd_q, phs_q;
  logic             run_q;
  logic [HS_W-1:0]  hs_q;
  logic [CK_W-1:0]  ck_q;
  logic [1:0]       shmode_q;
  logic [CNT_W-1:0] sh_q  [2];
  logic [CNT_W-1:0] act_q [2];
  logic [TBL_W-1:0] tbl_q [2];
  logic             pwm_q [2];
  logic             et_en_q;
  logic [1:0]       et_sel_q;
  logic [EVN_W-1:0] et_n_q;

  logic             tick;
  logic             cnt_wr;
  logic             irq_clr;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  tb_evt_t          evt;

  function automatic logic is_wr(input logic en, input logic [ADDR_W-1:0] a, input int idx);
    return en && (a == ADDR_W'(idx));
  endfunction

  always_comb begin
    cnt_wr  = is_wr(wr_en, wr_addr, A_CNT);
    irq_clr = is_wr(wr_en, wr_addr, A_INTCLR) && wr_data[0];
    ld      = cnt_wr || PHASE_LOAD_EN;
    ld_val  = cnt_wr ? wr_data : phs_q;
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      prd_q    <= '0;
      phs_q    <= '0;
      run_q    <= 1'b0;
      hs_q     <= '0;
      ck_q     <= '0;
      shmode_q <= '0;
      tbl_q[0] <= '0;
      tbl_q[1] <= '0;
      et_en_q  <= 1'b0;
      et_sel_q <= '0;
      et_n_q   <= '0;
    end else if (wr_en) begin
      case (int'(wr_addr))
        A_PRD:    prd_q <= wr_data;
        A_PHS:    phs_q <= wr_data;
        A_CTRL: begin
          run_q <= wr_data[0];
          hs_q  <= wr_data[HS_LO +: HS_W];
          ck_q  <= wr_data[CK_LO +: CK_W];
        end
        A_CMPCTL: shmode_q <= wr_data[1:0];
        A_AQA:    tbl_q[0] <= wr_data[TBL_W-1:0];
        A_AQB:    tbl_q[1] <= wr_data[TBL_W-1:0];
        A_ETSEL: begin
          et_en_q  <= wr_data[0];
          et_sel_q <= wr_data[2:1];
          et_n_q   <= wr_data[N_LO +: EVN_W];
        end
        default: ;
      endcase
    end
  end

  // event decode from current count, direction and active compares
  always_comb begin
    evt.zero  = (cnt_out == '0);
    evt.prd   = (cnt_out == prd_q);
    evt.ca_up = (cnt_out == act_q[0]) &&  dir_up;
    evt.ca_dn = (cnt_out == act_q[0]) && !dir_up;
    evt.cb_up = (cnt_out == act_q[1]) &&  dir_up;
    evt.cb_dn = (cnt_out == act_q[1]) && !dir_up;
  end

  updown_pwm_prescale #(.HS_W(HS_W), .CK_W(CK_W)) u_pre (
    .clk(clk), .rst(rst), .run(run_q), .clk_en(clk_en),
    .hs(hs_q), .ck(ck_q), .tick(tick)
  );

  updown_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(ld), .load_val(ld_val),
    .period(prd_q), .cnt(cnt_out), .dir_up(dir_up)
  );

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic cmp_wr;
    assign cmp_wr = is_wr(wr_en, wr_addr, A_CMPA + ch);

    always_ff @(posedge clk) begin
      if (rst) begin
        sh_q[ch]  <= '0;
        act_q[ch] <= '0;
      end else begin
        if (shmode_q[ch] && tick && evt.zero) act_q[ch] <= sh_q[ch];
        if (cmp_wr) begin
          if (shmode_q[ch]) sh_q[ch]  <= wr_data;
          else              act_q[ch] <= wr_data;
        end
      end
    end

    updown_pwm_aq u_aq (
      .clk(clk), .rst(rst), .tick(tick), .evt(evt),
      .tbl(tbl_q[ch]), .q(pwm_q[ch])
    );
  end

  assign pwm_a = pwm_q[0];
  assign pwm_b = pwm_q[1];

  updown_pwm_evtrig #(.EVN_W(EVN_W)) u_et (
    .clk(clk), .rst(rst), .tick(tick), .evt(evt), .en(et_en_q),
    .src_sel(et_sel_q), .n_evt(et_n_q), .clr(irq_clr), .flag(irq)
  );
endmodule

// File: rtl/updown_pwm_chk.sv
module updown_pwm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             cnt_wr,
  input logic             irq_clr,
  input logic [CNT_W-1:0] cnt,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic             irq
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (cnt == '0) && !pwm_a && !pwm_b && !irq); // R1

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)) ||
                          (cnt == CNT_W'($past(cnt) - 1'b1)) || (cnt == '0)); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr) |=> $stable(cnt)); // R3

  AST_OUT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pwm_a) && $stable(pwm_b)); // R6

  AST_IRQ_RISE_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !$rose(irq)); // R9

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq); // R10
endmodule

bind updown_pwm updown_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .cnt_wr(cnt_wr), .irq_clr(irq_clr),
  .cnt(cnt_out), .pwm_a(pwm_a), .pwm_b(pwm_b), .irq(irq)
);

// File: tb/tb_updown_pwm.sv
`timescale 1ns/1ps
module tb_updown_pwm;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_en = 1'b1;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [CNT_W-1:0] cnt_out;
  logic dir_up, pwm_a, pwm_b, irq;

  always #10 clk = ~clk;

  updown_pwm #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_out(cnt_out), .dir_up(dir_up), .pwm_a(pwm_a),
    .pwm_b(pwm_b), .irq(irq)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit cmp_on = 0, en_toggle = 0, done = 0;
  string tag = "R1";

  task automatic chk(input string t, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  // cycle-level model built from the requirements
  int m_cnt, m_prd, m_ctrl, m_sha, m_shb, m_aca, m_acb, m_cc, m_aqa, m_aqb, m_et, m_pre, m_ev;
  bit m_up, m_a, m_b, m_irq;

  function automatic bit act_on(input bit q, input int code);
    case (code)
      1: return 1'b0;
      2: return 1'b1;
      3: return ~q;
      default: return q;
    endcase
  endfunction

  function automatic int pick(input int tbl, input bit [5:0] ev);
    for (int i = 0; i < 6; i++)
      if (ev[i] && ((tbl >> (2*i)) & 3) != 0) return (tbl >> (2*i)) & 3;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit t, wr_c, setf, clr, src;
    bit [5:0] ev;
    int div, n;
    if (rst) begin
      m_cnt = 0; m_prd = 0; m_ctrl = 0; m_sha = 0; m_shb = 0; m_aca = 0; m_acb = 0;
      m_cc = 0; m_aqa = 0; m_aqb = 0; m_et = 0; m_pre = 0; m_ev = 0;
      m_up = 1; m_a = 0; m_b = 0; m_irq = 0;
    end else begin
      div = (((m_ctrl >> 1) & 7) + 1) << ((m_ctrl >> 4) & 7);
      t = 0;
      if ((m_ctrl & 1) == 0) m_pre = 0;
      else if (clk_en) begin
        if (m_pre == div - 1) begin t = 1; m_pre = 0; end
        else m_pre++;
      end
      wr_c = wr_en && wr_addr == 1;
      setf = 0;
      if (t) begin
        ev = {m_cnt == m_acb && !m_up, m_cnt == m_acb && m_up,
              m_cnt == m_aca && !m_up, m_cnt == m_aca && m_up,
              m_cnt == m_prd, m_cnt == 0};
        m_a = act_on(m_a, pick(m_aqa, ev));
        m_b = act_on(m_b, pick(m_aqb, ev));
        n = (m_et >> 3) & 7;
        case ((m_et >> 1) & 3)
          0: src = ev[0];
          1: src = ev[1];
          2: src = ev[0] | ev[1];
          default: src = ev[2];
        endcase
        if ((m_et & 1) && n != 0 && src) begin
          m_ev = (m_ev + 1) & 7;
          if (m_ev == n) begin setf = 1; m_ev = 0; end
        end
        if (m_cnt == 0) begin
          if (m_cc & 1) m_aca = m_sha;
          if (m_cc & 2) m_acb = m_shb;
        end
        if (!wr_c) begin
          if (m_up) begin
            if (m_cnt >= m_prd) begin
              if (m_cnt != 0) begin m_up = 0; m_cnt--; end
            end else m_cnt++;
          end else begin
            if (m_cnt == 0) begin m_up = 1; if (m_prd != 0) m_cnt = 1; end
            else m_cnt--;
          end
        end
      end
      clr = 0;
      if (wr_en) begin
        case (int'(wr_addr))
          0: m_prd = wr_data;
          1: begin m_cnt = wr_data; if (wr_data == 0) m_up = 1; end
          3: m_ctrl = wr_data & 'h7F;
          4: if (m_cc & 1) m_sha = wr_data; else m_aca = wr_data;
          5: if (m_cc & 2) m_shb = wr_data; else m_acb = wr_data;
          6: m_cc = wr_data & 3;
          7: m_aqa = wr_data & 'hFFF;
          8: m_aqb = wr_data & 'hFFF;
          9: m_et = wr_data & 'h3F;
          10: clr = wr_data[0];
          default: ;
        endcase
      end
      m_irq = (m_irq && !clr) || setf;
    end
  end

  always @(negedge clk) begin
    if (!rst && cmp_on) begin
      chk({tag, " count"}, cnt_out, m_cnt);
      chk({tag, " dir"}, dir_up, m_up);
      chk({tag, " pwm_a"}, pwm_a, m_a);
      chk({tag, " pwm_b"}, pwm_b, m_b);
      chk({tag, " irq"}, irq, m_irq);
    end
  end

  task automatic step();
    @(negedge clk);
    cyc++;
    if (en_toggle) clk_en = ~clk_en;
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = ADDR_W'(a); wr_data = CNT_W'(d);
    step();
    wr_en = 0;
    step();
  endtask

  task automatic wait_at(input int v, input bit up);
    int g = 0;
    while (!(cnt_out == v && dir_up == up) && g < 2000) begin step(); g++; end
  endtask

  task automatic gap_between_steps(output int n);
    int prev, g;
    prev = cnt_out; g = 0;
    while (cnt_out == prev && g < 500) begin step(); g++; end
    prev = cnt_out; n = 0;
    do begin step(); n++; end while (cnt_out == prev && n < 500);
  endtask

  initial begin
    int n, h, hb, t0;
    repeat (3) step();
    rst = 0;
    chk("R1 count", cnt_out, 0);
    chk("R1 dir", dir_up, 1);
    chk("R1 pwm_a", pwm_a, 0);
    chk("R1 pwm_b", pwm_b, 0);
    chk("R1 irq", irq, 0);
    cmp_on = 1;

    tag = "R6";
    wr(0, 5); wr(6, 3); wr(4, 2); wr(5, 3);
    wr(7, 'h21); wr(8, 'h102); wr(9, 'h19); wr(3, 1);
    repeat (25) step();

    tag = "R2";
    while (cnt_out != 0) step();
    n = 0;
    do begin step(); n++; end while (cnt_out != 0 && n < 100);
    chk("R2 cycle length", n, 10);

    tag = "R6";
    h = pwm_a; hb = pwm_b;
    repeat (9) begin step(); h += pwm_a; hb += pwm_b; end
    chk("R6 duty A", h, 10 - 2);
    chk("R6 duty B", hb, 3);

    tag = "R4";
    wait_at(1, 1); wr(4, 4);
    wait_at(3, 1);
    chk("R4 old compare kept", pwm_a, 1);
    repeat (12) step();

    tag = "R5";
    wr(6, 0);
    wait_at(1, 1); wr(4, 4);
    wait_at(3, 1);
    chk("R5 new compare live", pwm_a, 0);
    wait_at(5, 1);
    chk("R5 set at new compare", pwm_a, 1);

    tag = "R7";
    wr(7, 'h90); wr(4, 5);
    wait_at(3, 0); wait_at(4, 1); wait_at(4, 0);
    chk("R7 match at period is up", pwm_a, 0);
    wr(4, 0);
    wait_at(3, 0); wait_at(1, 1);
    chk("R7 match at zero is down", pwm_a, 1);

    tag = "R8";
    wait_at(3, 0); wr(7, 'h42);
    wait_at(1, 1);
    chk("R8 zero beats compare", pwm_a, 1);

    tag = "R9";
    wr(9, 'h19); wr(10, 1);
    n = 0;
    while (!irq && n < 200) begin step(); n++; end
    t0 = cyc; wr(10, 1);
    n = 0;
    while (!irq && n < 200) begin step(); n++; end
    chk("R9 every third zero", cyc - t0, 30);

    tag = "R10";
    wr(9, 0); wr(10, 0);
    repeat (40) step();
    chk("R10 flag held", irq, 1);
    wr(10, 1);
    chk("R10 flag cleared", irq, 0);

    tag = "R3";
    wr(3, 'h15);
    repeat (10) step();
    gap_between_steps(n);
    chk("R3 divide by 6", n, 6);
    en_toggle = 1;
    repeat (10) step();
    gap_between_steps(n);
    chk("R3 half-rate enable", n, 12);
    en_toggle = 0; clk_en = 1;
    wr(3, 0);
    h = cnt_out;
    repeat (20) step();
    chk("R3 stopped", cnt_out, h);

    tag = "R11";
    wr(3, 1);
    wait_at(4, 0); wr(1, 2);
    chk("R11 count override", cnt_out, 1);
    chk("R11 dir kept", dir_up, 0);
    wait_at(3, 0); wr(3, 0);
    wr(1, 0);
    chk("R11 zero forces up", dir_up, 1);

    tag = "R12";
    wr(1, 3);
    wr(2, 4); wr(3, 'h80);
    chk("R12 phase ignored", cnt_out, 3);
    wr(3, 'h81);
    repeat (30) step();

    tag = "R6";
    wr(6, 0); wr(7, 'h21); wr(8, 'h102);
    for (int p = 2; p <= 6; p++) begin
      for (int c = 0; c <= p; c++) begin
        wr(0, p); wr(4, c); wr(5, c);
        repeat (4 * p + 4) step();
      end
    end

    cmp_on = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule